// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block is the hardware half of a receive buffer-descriptor ring. Frames arrive as a byte stream. Each byte goes into the data buffer of the descriptor the ring pointer selects. When that buffer is finished, the engine writes the descriptor's status word. On the next cycle it sets the descriptor's used flag and moves the pointer on. The descriptor table and the buffer storage are held inside the block, so the producer only needs the stream and the consumer only needs a small slot-access port.

Each descriptor has two 32-bit words. The first is the address word: bits 31:2 give the buffer byte address, bit 0 is the used flag (set by hardware, cleared by the consumer) and bit 1 is the wrap flag. The second is the status word: bits 13:0 give the byte count, bit 14 marks the start of a frame, bit 15 marks the end of a frame, and bits 31:16 are kept as the consumer wrote them (normally `0xF000`).

A frame larger than one buffer continues into the following descriptors. If the engine reaches a descriptor whose used flag is still set, it discards bytes until the end of that frame and raises a one-cycle no-buffer pulse.

Back-pressure rules for the input stream:
- A byte is taken on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` does not depend on `in_valid`.
- `in_ready` drops only for the two write-back cycles that follow the byte that closed a descriptor.
- The producer must hold its byte and `in_last` steady while `in_ready` is low.

Top module: `rx_ring_writeback`

## Requirements
- R1: `in_ready` is high except during the two cycles after an accepted byte that closes a descriptor. A descriptor closes when its buffer fills or the byte carries `in_last`.
- R2: Byte k of a descriptor's share of a frame is stored at buffer byte address (address word with bits 1:0 cleared) + k, and can be read back on `rd_byte`.
- R3: The status written back holds the number of bytes placed in that descriptor in bits 13:0, start-of-frame in bit 14 and end-of-frame in bit 15. Bits 31:16 keep their previous value.
- R4: A descriptor closes after BUF_BYTES bytes. The rest of the frame continues in the next descriptor. Only the first descriptor of the frame carries bit 14, and only the last carries bit 15.
- R5: The used flag (address bit 0) is set one cycle after the status word is written, and the ring pointer advances in that same cycle.
- R6: After a descriptor with address bit 1 set, or after slot NDESC-1, the ring pointer returns to slot 0. Otherwise it steps to the next slot.
- R7: If the current slot is used when a frame starts, the whole frame is discarded. `nobuf` pulses for one cycle, and the pointer and descriptor are left unchanged.
- R8: If a used slot is reached in the middle of a frame, descriptors already written keep their contents, without end-of-frame. The remaining bytes are discarded, `nobuf` pulses, and reception resumes with the next frame.
- R9: The consumer port writes either word of slot `sw_idx`, clears only bit 0 of its address word with `sw_clr_used`, and reads both words combinationally.
- R10: Reset sets the ring pointer to 0 and zeroes all descriptor words. After reset `in_ready` is 1 and `nobuf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte is the final byte of the frame |
| in_ready | output | 1 | Engine can take a byte |
| nobuf | output | 1 | One-cycle pulse: frame (or its remainder) discarded because a slot was used |
| ring_ptr | output | IW | Index of the current descriptor slot |
| sw_idx | input | IW | Consumer port slot select |
| sw_wr_en | input | 1 | Write `sw_wdata` into the selected word |
| sw_wr_stat | input | 1 | Word select for writes: 1 status, 0 address |
| sw_wdata | input | 32 | Write data |
| sw_clr_used | input | 1 | Clear the used flag of slot `sw_idx` |
| sw_addr_q | output | 32 | Address word of slot `sw_idx` |
| sw_stat_q | output | 32 | Status word of slot `sw_idx` |
| rd_byte_addr | input | MAW | Buffer byte read address |
| rd_byte | output | 8 | Buffer byte at `rd_byte_addr` |

## Verification
A walked table of frames is the main test. Frame lengths are short, exactly one buffer, one byte over, several buffers and a single byte. These separate an off-by-one in the close rule from a wrong start/end marking and from lost length carry across descriptors. The frames run over several ring turns, which also exercises the end-of-table wrap. Directed cases then pre-set used flags, both at a frame start and at a mid-frame slot, to separate a whole-frame discard from a partial one. A wrap flag on a middle slot shows that the flag, and not the slot count, bounds the ring.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_WB_STAT, ST_WB_USED} wb_state_e;

  localparam int USED_BIT = 0;
  localparam int WRAP_BIT = 1;
  localparam int LEN_W    = 14;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  function automatic logic [31:0] pack_status(input logic [31:0] prev,
                                              input logic eof,
                                              input logic sof,
                                              input logic [LEN_W-1:0] len);
    return {prev[31:16], eof, sof, len};
  endfunction
endpackage

// File: rtl/rx_ring_desc_mem.sv
module rx_ring_desc_mem #(
  parameter int NDESC = 2,
  localparam int IW = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] sw_idx,
  input  logic          sw_wr_en,
  input  logic          sw_wr_stat,
  input  logic [31:0]   sw_wdata,
  input  logic          sw_clr_used,
  output logic [31:0]   sw_addr_q,
  output logic [31:0]   sw_stat_q,
  input  logic [IW-1:0] hw_idx,
  input  logic          hw_stat_we,
  input  logic [31:0]   hw_stat_wdata,
  input  logic          hw_used_set,
  output logic [31:0]   hw_addr_q,
  output logic [31:0]   hw_stat_q
);
  import rx_ring_pkg::*;

  logic [31:0] addr_w [NDESC];
  logic [31:0] stat_w [NDESC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        addr_w[i] <= '0;
        stat_w[i] <= '0;
      end
    end else begin
      if (sw_wr_en && !sw_wr_stat) addr_w[sw_idx] <= sw_wdata;
      if (sw_wr_en && sw_wr_stat)  stat_w[sw_idx] <= sw_wdata;
      if (sw_clr_used)             addr_w[sw_idx][USED_BIT] <= 1'b0;
      if (hw_stat_we)              stat_w[hw_idx] <= hw_stat_wdata;
      if (hw_used_set)             addr_w[hw_idx][USED_BIT] <= 1'b1;
    end
  end

  assign sw_addr_q = addr_w[sw_idx];
  assign sw_stat_q = stat_w[sw_idx];
  assign hw_addr_q = addr_w[hw_idx];
  assign hw_stat_q = stat_w[hw_idx];
endmodule

// File: rtl/rx_ring_buf_mem.sv
module rx_ring_buf_mem #(
  parameter int MEM_BYTES = 3072,
  localparam int MAW = $clog2(MEM_BYTES)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [31:0]    waddr,
  input  logic [7:0]     wdata,
  input  logic [MAW-1:0] raddr,
  output logic [7:0]     rdata
);
  logic [7:0] bytes_q [MEM_BYTES];
  logic       in_range;

  assign in_range = waddr < 32'(MEM_BYTES);

  always_ff @(posedge clk) begin
    if (we && in_range) bytes_q[waddr[MAW-1:0]] <= wdata;
  end

  assign rdata = (32'(raddr) < 32'(MEM_BYTES)) ? bytes_q[raddr] : 8'h00;
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int NDESC = 2,
  parameter int BUF_BYTES = 1536,
  localparam int IW = $clog2(NDESC),
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          nobuf,
  output logic [IW-1:0] ptr,
  input  logic [31:0]   cur_addr,
  input  logic [31:0]   cur_stat,
  output logic          buf_we,
  output logic [31:0]   buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic          stat_we,
  output logic [31:0]   stat_wdata,
  output logic          used_set
);
  import rx_ring_pkg::*;

  wb_state_e     st_q;
  logic [IW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic          open_q, in_frame_q, drop_q, sof_q, eof_q, nobuf_q;

  logic          beat, slot_free, take, close, ring_end;
  logic [CW-1:0] eff_cnt, next_cnt;

  assign in_ready  = (st_q == ST_RUN);
  assign beat      = in_valid && in_ready;
  assign slot_free = !cur_addr[USED_BIT];
  assign take      = beat && !drop_q && (open_q || slot_free);
  assign eff_cnt   = open_q ? cnt_q : '0;
  assign next_cnt  = eff_cnt + 1'b1;
  assign close     = take && (in_last || next_cnt == CW'(BUF_BYTES));
  assign ring_end  = cur_addr[WRAP_BIT] || (ptr_q == IW'(NDESC - 1));

  assign buf_we     = take;
  assign buf_waddr  = {cur_addr[31:2], 2'b00} + 32'(eff_cnt);
  assign buf_wdata  = in_data;
  assign stat_we    = (st_q == ST_WB_STAT);
  assign stat_wdata = pack_status(cur_stat, eof_q, sof_q, LEN_W'(cnt_q));
  assign used_set   = (st_q == ST_WB_USED);
  assign nobuf      = nobuf_q;
  assign ptr        = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      ptr_q      <= '0;
      cnt_q      <= '0;
      open_q     <= 1'b0;
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      sof_q      <= 1'b0;
      eof_q      <= 1'b0;
      nobuf_q    <= 1'b0;
    end else begin
      nobuf_q <= 1'b0;
      case (st_q)
        ST_RUN: begin
          if (beat) begin
            if (drop_q) begin
              if (in_last) begin
                drop_q     <= 1'b0;
                in_frame_q <= 1'b0;
              end
            end else if (!open_q && !slot_free) begin
              nobuf_q    <= 1'b1;
              drop_q     <= !in_last;
              in_frame_q <= !in_last;
            end else begin
              if (!open_q) sof_q <= !in_frame_q;
              open_q     <= 1'b1;
              in_frame_q <= !in_last;
              cnt_q      <= next_cnt;
              if (close) begin
                eof_q <= in_last;
                st_q  <= ST_WB_STAT;
              end
            end
          end
        end
        ST_WB_STAT: st_q <= ST_WB_USED;
        ST_WB_USED: begin
          ptr_q  <= ring_end ? '0 : ptr_q + 1'b1;
          open_q <= 1'b0;
          cnt_q  <= '0;
          st_q   <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writeback.sv
module rx_ring_writeback #(
  parameter int NDESC = 2,
  parameter int BUF_BYTES = 1536,
  localparam int IW = $clog2(NDESC),
  localparam int MEM_BYTES = NDESC * BUF_BYTES,
  localparam int MAW = $clog2(MEM_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  input  logic           in_last,
  output logic           in_ready,
  output logic           nobuf,
  output logic [IW-1:0]  ring_ptr,
  input  logic [IW-1:0]  sw_idx,
  input  logic           sw_wr_en,
  input  logic           sw_wr_stat,
  input  logic [31:0]    sw_wdata,
  input  logic           sw_clr_used,
  output logic [31:0]    sw_addr_q,
  output logic [31:0]    sw_stat_q,
  input  logic [MAW-1:0] rd_byte_addr,
  output logic [7:0]     rd_byte
);
  logic [31:0] cur_addr, cur_stat, buf_waddr, stat_wdata;
  logic [7:0]  buf_wdata;
  logic        buf_we, stat_we, used_set;

  rx_ring_ctrl #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .nobuf(nobuf), .ptr(ring_ptr),
    .cur_addr(cur_addr), .cur_stat(cur_stat),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .used_set(used_set)
  );

  rx_ring_desc_mem #(.NDESC(NDESC)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .sw_idx(sw_idx), .sw_wr_en(sw_wr_en), .sw_wr_stat(sw_wr_stat),
    .sw_wdata(sw_wdata), .sw_clr_used(sw_clr_used),
    .sw_addr_q(sw_addr_q), .sw_stat_q(sw_stat_q),
    .hw_idx(ring_ptr), .hw_stat_we(stat_we), .hw_stat_wdata(stat_wdata),
    .hw_used_set(used_set), .hw_addr_q(cur_addr), .hw_stat_q(cur_stat)
  );

  rx_ring_buf_mem #(.MEM_BYTES(MEM_BYTES)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(rd_byte_addr), .rdata(rd_byte)
  );
endmodule

// File: rtl/rx_ring_writeback_chk.sv
module rx_ring_writeback_chk #(
  parameter int NDESC = 2,
  parameter int BUF_BYTES = 1536,
  localparam int IW = $clog2(NDESC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          nobuf,
  input logic [IW-1:0] ring_ptr,
  input logic          stat_we,
  input logic [31:0]   stat_wdata,
  input logic          used_set,
  input logic [31:0]   cur_addr
);
  p_wb_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we || used_set) |-> !in_ready);

  p_len_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (stat_wdata[13:0] != 14'd0 && 32'(stat_wdata[13:0]) <= 32'(BUF_BYTES)));

  p_used_after_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    used_set |-> $past(stat_we));

  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !used_set |=> $stable(ring_ptr));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (used_set && cur_addr[1]) |=> (ring_ptr == '0));

  p_nobuf_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nobuf |-> $past(in_valid && in_ready));
endmodule

bind rx_ring_writeback rx_ring_writeback_chk #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .nobuf(nobuf), .ring_ptr(ring_ptr), .stat_we(stat_we), .stat_wdata(stat_wdata),
  .used_set(used_set), .cur_addr(cur_addr)
);

// File: tb/rx_ring_writeback_tb.sv
module rx_ring_writeback_tb;
  localparam int N   = 4;
  localparam int B   = 8;
  localparam int IW  = $clog2(N);
  localparam int MAW = $clog2(N * B);
  // columns: frame length, first byte value, descriptors consumed
  localparam int VEC_N = 6;
  localparam int VEC [VEC_N][3] = '{
    '{3, 8'h10, 1}, '{8, 8'h20, 1}, '{9, 8'h30, 2},
    '{20, 8'h50, 3}, '{1, 8'h70, 1}, '{17, 8'h80, 3}};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_ready, nobuf;
  logic [7:0] in_data = 0, rd_byte;
  logic [IW-1:0] ring_ptr, sw_idx = 0;
  logic sw_wr_en = 0, sw_wr_stat = 0, sw_clr_used = 0;
  logic [31:0] sw_wdata = 0, sw_addr_q, sw_stat_q;
  logic [MAW-1:0] rd_byte_addr = 0;

  int checks = 0, errors = 0, nobuf_cnt = 0, mptr = 0;
  logic ready_after = 1'b1;

  rx_ring_writeback #(.NDESC(N), .BUF_BYTES(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .nobuf(nobuf), .ring_ptr(ring_ptr),
    .sw_idx(sw_idx), .sw_wr_en(sw_wr_en), .sw_wr_stat(sw_wr_stat),
    .sw_wdata(sw_wdata), .sw_clr_used(sw_clr_used), .sw_addr_q(sw_addr_q),
    .sw_stat_q(sw_stat_q), .rd_byte_addr(rd_byte_addr), .rd_byte(rd_byte));

  always #4 clk = ~clk;

  always @(negedge clk) if (nobuf === 1'b1) nobuf_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input int idx, input bit stat, input logic [31:0] d);
    @(negedge clk);
    sw_idx = IW'(idx); sw_wr_en = 1; sw_wr_stat = stat; sw_wdata = d;
    @(negedge clk);
    sw_wr_en = 0;
  endtask

  task automatic ring_init(input int wrap_at);
    for (int i = 0; i < N; i++) begin
      sw_write(i, 0, 32'(i * B) | ((i == wrap_at) ? 32'h2 : 32'h0));
      sw_write(i, 1, 32'hF000_0000);
    end
  endtask

  task automatic read_desc(input int idx, output logic [31:0] a, output logic [31:0] s);
    @(negedge clk);
    sw_idx = IW'(idx);
    #1;
    a = sw_addr_q; s = sw_stat_q;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(seed + k); in_last = (k == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    ready_after = in_ready;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_chunk(input int idx, input int n, input bit sof, input bit eof,
                             input int seed);
    logic [31:0] a, s;
    bit bad;
    read_desc(idx, a, s);
    chk("R3 status word", s, {16'hF000, eof, sof, 14'(n)});
    chk("R5 used flag set", {31'd0, a[0]}, 32'd1);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      rd_byte_addr = MAW'(idx * B + k);
      #1;
      if (rd_byte !== 8'(seed + k)) bad = 1;
    end
    chk("R2 buffer bytes", {31'd0, bad}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, s;
    int nb0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R10 nobuf after reset", {31'd0, nobuf}, 32'd0);
    chk("R10 pointer after reset", 32'(ring_ptr), 32'd0);
    read_desc(2, a, s);
    chk("R10 descriptor cleared", a | s, 32'd0);
    ring_init(N - 1);

    // table walk: lengths around the buffer size, several ring turns
    for (int v = 0; v < VEC_N; v++) begin
      int rem, off, n, used_n;
      bit first;
      p0 = mptr;
      send_frame(VEC[v][0], VEC[v][1]);
      rem = VEC[v][0]; off = 0; first = 1; used_n = 0;
      while (rem > 0) begin
        n = (rem < B) ? rem : B;
        check_chunk(mptr, n, first, rem == n, VEC[v][1] + off);
        mptr = (mptr == N - 1) ? 0 : mptr + 1;
        rem -= n; off += n; first = 0; used_n++;
      end
      chk("R4 descriptors per frame", 32'(used_n), 32'(VEC[v][2]));
      chk("R6 ring pointer", 32'(ring_ptr), 32'(mptr));
      ring_init(N - 1);
    end

    // R7: used slot at frame start
    sw_write(mptr, 0, 32'(mptr * B) | 32'h3);
    nb0 = nobuf_cnt;
    send_frame(5, 8'h90);
    chk("R7 nobuf pulse count", 32'(nobuf_cnt - nb0), 32'd1);
    chk("R7 pointer unchanged", 32'(ring_ptr), 32'(mptr));
    read_desc(mptr, a, s);
    chk("R7 status untouched", s, 32'hF000_0000);
    ring_init(N - 1);
    send_frame(2, 8'hA0);
    check_chunk(mptr, 2, 1, 1, 8'hA0);
    mptr = (mptr == N - 1) ? 0 : mptr + 1;

    // R8: used slot reached mid-frame
    ring_init(N - 1);
    sw_write((mptr + 1) % N, 0, 32'(((mptr + 1) % N) * B) | 32'h1);
    nb0 = nobuf_cnt;
    send_frame(12, 8'h40);
    read_desc(mptr, a, s);
    chk("R8 partial descriptor kept", s, 32'hF000_4008);
    chk("R8 nobuf pulse count", 32'(nobuf_cnt - nb0), 32'd1);
    mptr = (mptr + 1) % N;
    chk("R8 pointer at blocked slot", 32'(ring_ptr), 32'(mptr));
    read_desc(mptr, a, s);
    chk("R8 blocked slot untouched", s, 32'hF000_0000);
    ring_init(N - 1);
    send_frame(3, 8'hB0);
    check_chunk(mptr, 3, 1, 1, 8'hB0);

    // R6/R1/R9: wrap flag on slot 1 after a fresh reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R10 pointer after second reset", 32'(ring_ptr), 32'd0);
    ring_init(1);
    send_frame(8, 8'hC0);
    chk("R1 ready low after closing byte", {31'd0, ready_after}, 32'd0);
    chk("R6 step to slot 1", 32'(ring_ptr), 32'd1);
    send_frame(8, 8'hC8);
    chk("R6 wrap flag returns to slot 0", 32'(ring_ptr), 32'd0);
    @(negedge clk); sw_idx = 0; sw_clr_used = 1;
    @(negedge clk); sw_clr_used = 0;
    read_desc(0, a, s);
    chk("R9 clear used keeps other bits", a, 32'h0000_0000);
    read_desc(1, a, s);
    chk("R9 slot 1 still used with wrap", a, 32'h0000_000B);
    send_frame(8, 8'hD0);
    check_chunk(0, 8, 1, 1, 8'hD0);
    chk("R6 pointer after third frame", 32'(ring_ptr), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule